// File: doc/BRIEF.md
# Instruction Prefetch Queue Controller

This block sits between a 16-bit memory bus and an instruction consumer. It keeps a small byte queue of instruction code filled ahead of demand. It forms a 20-bit fetch address from a 16-bit code segment and a 16-bit fetch offset. When the queue has room it asks the memory side for a word, or for a single byte when the offset is odd. It accepts the returned bytes and hands them to the consumer one at a time over a valid/ready handshake.

Operand accesses from the execution side take priority over new fetches. An operand access never cuts into a fetch that is already on the bus: it waits for that fetch to finish. Loading a branch target empties the queue and restarts fetching at the new segment and offset. If a fetch is still outstanding at that moment, the bytes it returns are thrown away. A 2-bit status output reports, one cycle later, what happened to the queue in each cycle.

Top module: `prefetch_queue`

## Requirements
- R1: The queue holds at most 6 bytes and delivers them in the order of their addresses. `byteValid` is high exactly when at least one byte is held, so the consumer stalls while the queue is empty.
- R2: `fetchReq` rises only in the cycle after a cycle in which no fetch was outstanding, at least two slots were free, `operandReq` was low and `branchLoad` was low.
- R3: When the fetch offset is even, the request has `fetchWord`=1. The byte at the request address is taken from `fetchData[7:0]` and the next byte from `fetchData[15:8]`, and the offset advances by 2. When the offset is odd, the request has `fetchWord`=0 and only `fetchData[15:8]` is used. The offset then advances by 1, so the next request is even-aligned.
- R4: `fetchAddr` equals segment×16 plus offset, taken modulo 2^20.
- R5: Once raised, `fetchReq` stays high with a stable `fetchAddr` until the cycle in which `fetchAck` is high. `operandGo` is high only when `operandReq` is high and no fetch is outstanding, so an outstanding fetch always completes first.
- R6: A cycle with `branchLoad` high empties the queue, so `byteValid` is low in the next cycle. The next fetch uses `branchSeg` and `branchOff`.
- R7: The data returned for a fetch that was outstanding when `branchLoad` was high is discarded. The first byte delivered after the branch comes from the branch target.
- R8: `queueStatus` is registered and describes the previous cycle: 00 when nothing happened, 01 when a byte was taken with `firstByte`=1, 11 when a byte was taken with `firstByte`=0, and 10 when the queue was flushed.
- R9: The fetch offset wraps from 0xFFFF to 0x0000 and the segment does not change.
- R10: If `branchLoad` and a consumer handshake fall in the same cycle, the flush wins and `queueStatus` shows 10 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset. Segment and offset reset to 0 |
| branchLoad | input | 1 | Flush the queue and load a new fetch position |
| branchSeg | input | 16 | New code segment |
| branchOff | input | 16 | New fetch offset |
| operandReq | input | 1 | An operand access is pending |
| operandGo | output | 1 | The bus is free for the pending operand access |
| fetchReq | output | 1 | A fetch is outstanding |
| fetchAddr | output | 20 | Physical address of the outstanding fetch |
| fetchWord | output | 1 | 1 for a two-byte fetch, 0 for a single odd byte |
| fetchAck | input | 1 | Fetch data is present on fetchData in this cycle |
| fetchData | input | 16 | Returned fetch data |
| byteValid | output | 1 | A byte is available to the consumer |
| byteData | output | 8 | Oldest queued byte |
| byteReady | input | 1 | The consumer takes the byte |
| firstByte | input | 1 | The byte taken is the first byte of an instruction |
| queueStatus | output | 2 | Queue activity code of the previous cycle |

## Verification
The hardest situation to reach from the ports is a branch that lands while a fetch is still on the bus. The queue is normally full and idle, so the bench first stops the memory responder and branches to raise a fetch to a known address. It then branches again while that fetch waits for data. After releasing the responder, it checks that the stale data never appears and that the next request and the delivered bytes come from the second target. The bench also fills the queue to its limit with consumption stopped. It then removes bytes one at a time to find the exact moment fetching resumes, and it drives a flush and a handshake in the same cycle.

// File: rtl/pfq_pkg.sv
`timescale 1ns/1ps
package pfq_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic flush;   // empty queue, load branch target
    logic issue;   // latch a new fetch request
    logic accept;  // write returned bytes into the queue
    logic pop;     // consumer took the head byte
  } pfq_strobe_t;

  localparam logic [1:0] QS_NONE  = 2'b00;
  localparam logic [1:0] QS_FIRST = 2'b01;
  localparam logic [1:0] QS_FLUSH = 2'b10;
  localparam logic [1:0] QS_NEXT  = 2'b11;

endpackage

// File: rtl/pfq_datapath.sv
`timescale 1ns/1ps
module pfq_datapath
  import pfq_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int ADDR_W = 20,
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH),
  localparam int SHIFT = ADDR_W - SEG_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  pfq_strobe_t         strb,
  input  logic [SEG_W-1:0]    branchSeg,
  input  logic [OFF_W-1:0]    branchOff,
  input  logic [2*BYTE_W-1:0] fetchData,
  output logic [CNT_W-1:0]    cnt,
  output logic [BYTE_W-1:0]   byteData,
  output logic [ADDR_W-1:0]   fetchAddr,
  output logic                fetchWord
);

  logic [SEG_W-1:0]  segReg;
  logic [OFF_W-1:0]  offReg;
  logic [ADDR_W-1:0] addrReg;
  logic              wordReg;
  logic [PTR_W-1:0]  rdPtr, wrPtr, wrPtr1;
  logic [BYTE_W-1:0] slot [DEPTH];
  logic [ADDR_W-1:0] physAddr;
  logic [BYTE_W-1:0] lowByte, highByte;
  logic [CNT_W-1:0]  nBytes;

  function automatic logic [PTR_W-1:0] ptrInc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign physAddr = {segReg, {SHIFT{1'b0}}} + ADDR_W'(offReg);
  assign wrPtr1   = ptrInc(wrPtr);
  // odd-address bytes travel on the upper lane
  assign lowByte  = wordReg ? fetchData[BYTE_W-1:0] : fetchData[2*BYTE_W-1:BYTE_W];
  assign highByte = fetchData[2*BYTE_W-1:BYTE_W];
  assign nBytes   = wordReg ? CNT_W'(2) : CNT_W'(1);

  always_ff @(posedge clk) begin
    if (strb.accept) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wrPtr == PTR_W'(i))
          slot[i] <= lowByte;
        else if (wordReg && wrPtr1 == PTR_W'(i))
          slot[i] <= highByte;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      segReg  <= '0;
      offReg  <= '0;
      addrReg <= '0;
      wordReg <= 1'b0;
      rdPtr   <= '0;
      wrPtr   <= '0;
      cnt     <= '0;
    end else if (strb.flush) begin
      segReg <= branchSeg;
      offReg <= branchOff;
      rdPtr  <= '0;
      wrPtr  <= '0;
      cnt    <= '0;
    end else begin
      if (strb.issue) begin
        addrReg <= physAddr;
        wordReg <= ~offReg[0];
      end
      if (strb.accept) begin
        wrPtr  <= wordReg ? ptrInc(wrPtr1) : wrPtr1;
        offReg <= offReg + OFF_W'(nBytes);
      end
      if (strb.pop)
        rdPtr <= ptrInc(rdPtr);
      cnt <= cnt + (strb.accept ? nBytes : CNT_W'(0)) - CNT_W'(strb.pop);
    end
  end

  assign byteData  = slot[rdPtr];
  assign fetchAddr = addrReg;
  assign fetchWord = wordReg;

  // R1
  cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));

  // R3
  fetch_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.issue |=> (fetchWord == ~fetchAddr[0]));

endmodule

// File: rtl/pfq_control.sv
`timescale 1ns/1ps
module pfq_control
  import pfq_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             branchLoad,
  input  logic             operandReq,
  input  logic             fetchAck,
  input  logic             byteReady,
  input  logic             firstByte,
  input  logic [CNT_W-1:0] cnt,
  output pfq_strobe_t      strb,
  output logic             fetchReq,
  output logic             operandGo,
  output logic             byteValid,
  output logic [1:0]       queueStatus
);

  logic busy;      // fetch outstanding on the bus
  logic dropFlag;  // outstanding fetch belongs to a flushed stream
  logic roomOk;

  assign roomOk      = cnt <= CNT_W'(DEPTH - 2);
  assign byteValid   = cnt != '0;
  assign strb.flush  = branchLoad;
  assign strb.issue  = !busy && roomOk && !operandReq && !branchLoad;
  assign strb.accept = busy && fetchAck && !dropFlag && !branchLoad;
  assign strb.pop    = byteValid && byteReady && !branchLoad;
  assign fetchReq    = busy;
  assign operandGo   = operandReq && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      dropFlag    <= 1'b0;
      queueStatus <= QS_NONE;
    end else begin
      if (strb.issue)
        busy <= 1'b1;
      else if (fetchAck)
        busy <= 1'b0;

      if (busy && fetchAck)
        dropFlag <= 1'b0;
      else if (busy && branchLoad)
        dropFlag <= 1'b1;

      if (branchLoad)
        queueStatus <= QS_FLUSH;
      else if (strb.pop)
        queueStatus <= firstByte ? QS_FIRST : QS_NEXT;
      else
        queueStatus <= QS_NONE;
    end
  end

  // R2
  fetch_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetchReq) |-> ($past(cnt) <= CNT_W'(DEPTH - 2)) && !$past(operandReq));

  // R5
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetchReq && !fetchAck |=> fetchReq);

  // R8
  status_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byteValid && byteReady && !branchLoad |=> queueStatus[0]);

endmodule

// File: rtl/prefetch_queue.sv
`timescale 1ns/1ps
module prefetch_queue
  import pfq_pkg::*;
#(
  parameter int DEPTH  = 6,
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int ADDR_W = 20,
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                branchLoad,
  input  logic [SEG_W-1:0]    branchSeg,
  input  logic [OFF_W-1:0]    branchOff,
  input  logic                operandReq,
  output logic                operandGo,
  output logic                fetchReq,
  output logic [ADDR_W-1:0]   fetchAddr,
  output logic                fetchWord,
  input  logic                fetchAck,
  input  logic [2*BYTE_W-1:0] fetchData,
  output logic                byteValid,
  output logic [BYTE_W-1:0]   byteData,
  input  logic                byteReady,
  input  logic                firstByte,
  output logic [1:0]          queueStatus
);

  pfq_strobe_t      strb;
  logic [CNT_W-1:0] cnt;

  pfq_control #(.DEPTH(DEPTH)) ctrl_i (
    .clk, .rst_n, .branchLoad, .operandReq, .fetchAck, .byteReady,
    .firstByte, .cnt, .strb, .fetchReq, .operandGo, .byteValid, .queueStatus
  );

  pfq_datapath #(
    .DEPTH(DEPTH), .SEG_W(SEG_W), .OFF_W(OFF_W),
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)
  ) dp_i (
    .clk, .rst_n, .strb, .branchSeg, .branchOff, .fetchData,
    .cnt, .byteData, .fetchAddr, .fetchWord
  );

  // R5
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetchReq && !fetchAck |=> $stable(fetchAddr));

  // R6
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    branchLoad |=> !byteValid && (queueStatus == QS_FLUSH));

endmodule

// File: tb/prefetch_queue_tb_top.sv
`timescale 1ns/1ps
module prefetch_queue_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        branchLoad = 1'b0;
  logic [15:0] branchSeg = '0, branchOff = '0;
  logic        operandReq = 1'b0;
  logic        operandGo, fetchReq, fetchWord;
  logic [19:0] fetchAddr;
  logic        fetchAck = 1'b0;
  logic [15:0] fetchData = '0;
  logic        byteValid, byteReady = 1'b0, firstByte = 1'b0;
  logic [7:0]  byteData;
  logic [1:0]  queueStatus;

  int nChecks = 0, nFail = 0;
  logic memEn = 1'b0;
  int lat = 1, waitCnt = 0;
  logic [15:0] expSeg = '0, expOff = '0;

  always #2.5 clk = ~clk;

  prefetch_queue dut_i (.*);

  function automatic logic [7:0] memByte(input logic [19:0] p);
    return p[7:0] ^ {p[11:8], p[19:16]} ^ 8'h3C;
  endfunction

  function automatic logic [19:0] expAddr();
    return {expSeg, 4'h0} + {4'h0, expOff};
  endfunction

  // memory responder, acts 1 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk); #1;
      if (fetchAck) begin
        fetchAck = 1'b0;
        waitCnt  = 0;
      end else if (memEn && fetchReq) begin
        if (waitCnt >= lat) begin
          fetchAck  = 1'b1;
          fetchData = fetchWord ? {memByte(fetchAddr + 20'd1), memByte(fetchAddr)}
                                : {memByte(fetchAddr), 8'hEE};
        end else waitCnt++;
      end else waitCnt = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    memEn = 1'b1;
    repeat (30) @(negedge clk);
  endtask

  task automatic branchTo(input logic [15:0] seg, input logic [15:0] off);
    @(negedge clk);
    branchLoad = 1'b1; branchSeg = seg; branchOff = off;
    @(negedge clk);
    branchLoad = 1'b0;
    chk("R6 empty after branch", byteValid, 1'b0);
    chk("R8 flush status", queueStatus, 2'b10);
    expSeg = seg; expOff = off;
  endtask

  task automatic popOne(input logic fb, input string tag);
    int n = 0;
    while (!byteValid && n < 200) begin @(negedge clk); n++; end
    chk(tag, byteData, memByte(expAddr()));
    byteReady = 1'b1; firstByte = fb;
    @(negedge clk);
    byteReady = 1'b0;
    chk("R8 pop status", queueStatus, fb ? 2'b01 : 2'b11);
    expOff = expOff + 16'd1;
  endtask

  task automatic waitAck();
    int n = 0;
    while (!fetchAck && n < 200) begin @(negedge clk); n++; end
  endtask

  task automatic waitReqNew();
    int n = 0;
    @(negedge clk);
    while (!(fetchReq && !fetchAck) && n < 200) begin @(negedge clk); n++; end
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk("R1 reset byteValid", byteValid, 1'b0);
    chk("R2 reset fetchReq", fetchReq, 1'b0);
    chk("R8 reset status", queueStatus, 2'b00);
    rst_n = 1'b1;
  endtask

  task automatic testStream();
    settle();
    branchTo(16'h1234, 16'h0010);
    waitReqNew();
    chk("R4 stream addr", fetchAddr, 20'h12350);
    chk("R3 even word fetch", fetchWord, 1'b1);
    for (int i = 0; i < 12; i++) popOne(i % 3 == 0, "R1 stream order");
    @(negedge clk);
    chk("R8 idle status", queueStatus, 2'b00);
  endtask

  task automatic testOdd();
    settle();
    branchTo(16'h0100, 16'h0003);
    waitReqNew();
    chk("R4 odd addr", fetchAddr, 20'h01003);
    chk("R3 odd byte fetch", fetchWord, 1'b0);
    waitAck();
    waitReqNew();
    chk("R3 realigned addr", fetchAddr, 20'h01004);
    chk("R3 realigned word", fetchWord, 1'b1);
    for (int i = 0; i < 5; i++) popOne(i == 0, "R3 odd data");
  endtask

  task automatic testFull();
    branchTo(16'h0ABC, 16'h0100);
    settle();
    chk("R2 full no fetch", fetchReq, 1'b0);
    memEn = 1'b0;
    popOne(1'b1, "R1 full data");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2 one slot free no fetch", fetchReq, 1'b0);
    end
    popOne(1'b0, "R1 full data");
    @(negedge clk);
    chk("R2 two slots free fetch", fetchReq, 1'b1);
    for (int i = 0; i < 4; i++) popOne(1'b0, "R1 full data");
    @(negedge clk);
    chk("R1 capacity six then stall", byteValid, 1'b0);
    memEn = 1'b1;
  endtask

  task automatic testOperand();
    settle();
    memEn = 1'b0;
    branchTo(16'h0200, 16'h0000);
    waitReqNew();
    operandReq = 1'b1;
    @(negedge clk);
    chk("R5 operand waits", operandGo, 1'b0);
    chk("R5 fetch held", fetchReq, 1'b1);
    chk("R5 addr held", fetchAddr, 20'h02000);
    memEn = 1'b1;
    waitAck();
    @(negedge clk);
    chk("R5 operand granted", operandGo, 1'b1);
    chk("R5 fetch done", fetchReq, 1'b0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R2 operand blocks fetch", fetchReq, 1'b0);
    end
    operandReq = 1'b0;
    for (int i = 0; i < 4; i++) popOne(1'b0, "R5 data after operand");
  endtask

  task automatic testFlushInflight();
    settle();
    memEn = 1'b0;
    branchTo(16'h0000, 16'h0100);
    waitReqNew();
    chk("R4 first target addr", fetchAddr, 20'h00100);
    branchTo(16'h2000, 16'h0040);
    memEn = 1'b1;
    waitAck();
    waitReqNew();
    chk("R7 refetch addr", fetchAddr, 20'h20040);
    for (int i = 0; i < 4; i++) popOne(i == 0, "R7 stale data dropped");
  endtask

  task automatic testWrap();
    settle();
    branchTo(16'h0500, 16'hFFFD);
    waitReqNew();
    chk("R4 wrap start addr", fetchAddr, 20'h14FFD);
    for (int i = 0; i < 6; i++) popOne(1'b0, "R9 offset wrap data");
    settle();
    branchTo(16'hFFFF, 16'h0020);
    waitReqNew();
    chk("R4 address modulo", fetchAddr, 20'h00010);
  endtask

  task automatic testFlushPop();
    settle();
    @(negedge clk);
    chk("R10 queue has byte", byteValid, 1'b1);
    byteReady = 1'b1; firstByte = 1'b1;
    branchLoad = 1'b1; branchSeg = 16'h3000; branchOff = 16'h0008;
    @(negedge clk);
    byteReady = 1'b0; branchLoad = 1'b0;
    chk("R10 flush beats pop", queueStatus, 2'b10);
    chk("R10 empty", byteValid, 1'b0);
    expSeg = 16'h3000; expOff = 16'h0008;
    popOne(1'b1, "R10 new stream data");
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    testReset();
    testStream();
    testOdd();
    testFull();
    testOperand();
    testFlushInflight();
    testWrap();
    testFlushPop();
    finishRun();
  end

endmodule